// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block forms the product of two 32-bit binary floating-point words in one combinational pass. Each word carries a sign bit at position 31, an 8-bit exponent with a bias of 127 at positions 30 down to 23, and a 23-bit fraction at positions 22 down to 0. A normal value has an implied leading one above its fraction. The block returns the 32-bit product and two status bits: one reports a result that is too large, and one reports a result that is too small.

Operands that are not ordinary normals are resolved first through a fixed priority chain. A not-a-number operand is handled first. Infinity multiplied by zero is handled next, then any infinity, then any zero. An operand with a zero exponent counts as zero whatever its fraction. When both operands are normal, the block adds the exponents and forms the full 48-bit significand product. It normalizes that product and rounds it to nearest, with ties going to the even value. A result whose exponent is too large saturates to a signed infinity. A result whose exponent is too small is flushed to a signed zero. The block never produces a subnormal value.

The block has no clock and no state. A surrounding pipeline registers the operands and the outputs as its timing needs.

Top module: `fpmul_sp`

## Requirements
- R1: If either operand is not-a-number (exponent 255 with a non-zero fraction), the result is 32'h7FC00000 and both flags are 0. This rule takes priority over all others.
- R2: If one operand is infinity (exponent 255, fraction 0) and the other is zero (exponent 0), the result is 32'h7FC00000 and both flags are 0.
- R3: If either operand is infinity and R1 and R2 do not apply, the result is infinity: exponent 255, fraction 0, sign equal to the XOR of the operand signs. The overflow flag is 1 and the underflow flag is 0.
- R4: If either operand has exponent 0 and R1 to R3 do not apply, the result is zero with sign equal to the XOR of the operand signs, and both flags are 0. This holds whether the fraction is zero or not.
- R5: Every result other than 32'h7FC00000 has a sign bit equal to the XOR of bits 31 of the two operands.
- R6: For two normal operands, the exponent is exp_a + exp_b - 127. If the 48-bit significand product has bit 47 set, the exponent is one higher and the fraction is taken from product bits 46 to 24. Otherwise the fraction is taken from bits 45 to 23. Exact products are returned unchanged.
- R7: The product is rounded to nearest using the bit just below the fraction as the guard bit and the OR of all lower bits as the sticky bit. The fraction is incremented when the guard bit is 1 and either the sticky bit or the fraction LSB is 1. An exact tie therefore rounds to an even fraction.
- R8: If rounding carries out of the 23-bit fraction, the fraction becomes 0 and the exponent rises by one more. This happens before the range checks.
- R9: If the final exponent is 255 or more, the result is signed infinity with overflow 1 and underflow 0.
- R10: If the final exponent is 0 or less, the result is signed zero with underflow 1 and overflow 0.
- R11: The two flags are never both 1, and a result with exponent 0 always has fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Product word |
| overflow | output | 1 | Result saturated to infinity, or an infinity operand was involved |
| underflow | output | 1 | Result flushed to zero because its exponent was too small |

## Verification
The assertions check the block combinationally. They assume that both operands are fully driven with known bit values whenever they are evaluated, and that the check is made after the inputs have settled within a step. The bench meets this by changing the operands only on the rising clock edge and reading the outputs at the falling edge. Random operands are built from their separate fields: exponents are drawn from bands near the extremes, from the middle range and from the special codes 0 and 255. Every operand class, including the exponent sums just outside the representable range, is therefore reached with operands that are always known values.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EXPI_W = EXP_W + 2;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        cls_e              cls;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } opnd_t;

    function automatic fp_word_t make_word(input logic s,
                                           input logic [EXP_W-1:0] e,
                                           input logic [FRAC_W-1:0] f);
        fp_word_t w;
        w.sign = s;
        w.exp  = e;
        w.frac = f;
        return w;
    endfunction

    function automatic fp_word_t quiet_nan();
        return make_word(1'b0, {EXP_W{1'b1}}, {1'b1, {(FRAC_W-1){1'b0}}});
    endfunction

    function automatic fp_word_t signed_inf(input logic s);
        return make_word(s, {EXP_W{1'b1}}, {FRAC_W{1'b0}});
    endfunction

    function automatic fp_word_t signed_zero(input logic s);
        return make_word(s, {EXP_W{1'b0}}, {FRAC_W{1'b0}});
    endfunction

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
(
    input  fp_word_t w_i,
    output opnd_t    o_o
);

    always_comb begin
        o_o.sign = w_i.sign;
        o_o.exp  = w_i.exp;
        o_o.sig  = {1'b1, w_i.frac};
        if (w_i.exp == {EXP_W{1'b1}}) begin
            o_o.cls = (w_i.frac != '0) ? CLS_NAN : CLS_INF;
        end else if (w_i.exp == '0) begin
            o_o.cls = CLS_ZERO;
        end else begin
            o_o.cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fpm_sig_round.sv
module fpm_sig_round
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0]  sig_a_i,
    input  logic [SIG_W-1:0]  sig_b_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [1:0]        exp_inc_o
);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] norm;
    logic              hi;
    logic [FRAC_W-1:0] kept;
    logic              guard;
    logic              sticky;
    logic              round_up;
    logic [FRAC_W:0]   sum;
    logic              carry;

    always_comb begin
        prod     = PROD_W'(sig_a_i) * PROD_W'(sig_b_i);
        hi       = prod[PROD_W-1];
        norm     = hi ? prod : {prod[PROD_W-2:0], 1'b0};
        kept     = norm[PROD_W-2 -: FRAC_W];
        guard    = norm[PROD_W-2-FRAC_W];
        sticky   = |norm[PROD_W-3-FRAC_W:0];
        round_up = guard & (sticky | kept[0]);
        sum      = {1'b0, kept} + {{FRAC_W{1'b0}}, round_up};
        carry    = sum[FRAC_W];
        frac_o   = sum[FRAC_W-1:0];
        exp_inc_o = {1'b0, hi} + {1'b0, carry};
    end

    always_comb begin
        // R6: both significands carry a leading one, so the normalized product must too
        a_r6_norm_leading_one: assert (!(sig_a_i[SIG_W-1] && sig_b_i[SIG_W-1]) || norm[PROD_W-1])
            else $error("normalized product lost its leading one");
        // R8: a carry out of the fraction needs an all-ones fraction and a set guard bit
        a_r8_carry_needs_full_fraction: assert (!carry || ((&kept) && guard))
            else $error("rounding carry without saturated fraction");
    end

endmodule

// File: rtl/fpm_exp_adjust.sv
module fpm_exp_adjust
    import fpm_pkg::*;
(
    input  logic [EXP_W-1:0]         exp_a_i,
    input  logic [EXP_W-1:0]         exp_b_i,
    input  logic [1:0]               exp_inc_i,
    output logic [EXP_W-1:0]         exp_o,
    output logic                     too_big_o,
    output logic                     too_small_o
);

    logic [EXPI_W-1:0] sum;

    always_comb begin
        sum = {2'b00, exp_a_i} + {2'b00, exp_b_i}
            + {{(EXPI_W-2){1'b0}}, exp_inc_i}
            - EXPI_W'(BIAS);
        exp_o       = sum[EXP_W-1:0];
        too_small_o = sum[EXPI_W-1] || (sum == '0);
        too_big_o   = !sum[EXPI_W-1] && (sum[EXPI_W-2:0] >= (EXPI_W-1)'(EXP_MAX));
    end

    always_comb begin
        // R11: one exponent cannot be both above and below range
        a_r11_range_exclusive: assert (!(too_big_o && too_small_o))
            else $error("exponent flagged both too big and too small");
    end

endmodule

// File: rtl/fpm_select.sv
module fpm_select
    import fpm_pkg::*;
(
    input  opnd_t             op_a_i,
    input  opnd_t             op_b_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              too_big_i,
    input  logic              too_small_i,
    output fp_word_t          res_o,
    output logic              ovf_o,
    output logic              unf_o
);

    logic sgn;
    logic any_nan;
    logic any_inf;
    logic any_zero;
    logic inf_zero;

    always_comb begin
        sgn      = op_a_i.sign ^ op_b_i.sign;
        any_nan  = (op_a_i.cls == CLS_NAN)  || (op_b_i.cls == CLS_NAN);
        any_inf  = (op_a_i.cls == CLS_INF)  || (op_b_i.cls == CLS_INF);
        any_zero = (op_a_i.cls == CLS_ZERO) || (op_b_i.cls == CLS_ZERO);
        inf_zero = any_inf && any_zero;

        res_o = make_word(sgn, exp_i, frac_i);
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (any_nan || inf_zero) begin
            res_o = quiet_nan();
        end else if (any_inf) begin
            res_o = signed_inf(sgn);
            ovf_o = 1'b1;
        end else if (any_zero) begin
            res_o = signed_zero(sgn);
        end else if (too_big_i) begin
            res_o = signed_inf(sgn);
            ovf_o = 1'b1;
        end else if (too_small_i) begin
            res_o = signed_zero(sgn);
            unf_o = 1'b1;
        end
    end

    always_comb begin
        // R11: no subnormal result ever leaves the block
        a_r11_no_subnormal_out: assert ((res_o.exp != '0) || (res_o.frac == '0))
            else $error("subnormal result produced");
        // R3: an infinity operand outside the invalid cases always raises overflow
        a_r3_inf_raises_overflow: assert (!(any_inf && !any_nan && !any_zero) || ovf_o)
            else $error("infinity operand without overflow flag");
    end

endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] result,
    output logic              overflow,
    output logic              underflow
);

    localparam int N_OPS = 2;

    fp_word_t          words [N_OPS];
    opnd_t             ops   [N_OPS];
    logic [FRAC_W-1:0] frac_r;
    logic [1:0]        exp_inc;
    logic [EXP_W-1:0]  exp_f;
    logic              too_big;
    logic              too_small;
    fp_word_t          res_w;

    assign words[0] = fp_word_t'(a);
    assign words[1] = fp_word_t'(b);

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fpm_classify u_cls (
            .w_i (words[i]),
            .o_o (ops[i])
        );
    end

    fpm_sig_round u_round (
        .sig_a_i   (ops[0].sig),
        .sig_b_i   (ops[1].sig),
        .frac_o    (frac_r),
        .exp_inc_o (exp_inc)
    );

    fpm_exp_adjust u_exp (
        .exp_a_i     (ops[0].exp),
        .exp_b_i     (ops[1].exp),
        .exp_inc_i   (exp_inc),
        .exp_o       (exp_f),
        .too_big_o   (too_big),
        .too_small_o (too_small)
    );

    fpm_select u_sel (
        .op_a_i      (ops[0]),
        .op_b_i      (ops[1]),
        .frac_i      (frac_r),
        .exp_i       (exp_f),
        .too_big_i   (too_big),
        .too_small_i (too_small),
        .res_o       (res_w),
        .ovf_o       (overflow),
        .unf_o       (underflow)
    );

    assign result = res_w;

    always_comb begin
        // R11: flags are mutually exclusive at the ports
        a_r11_flags_exclusive: assert (!(overflow && underflow))
            else $error("both flags raised");
        // R9: overflow always comes with an infinite magnitude
        a_r9_overflow_is_inf: assert (!overflow || (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}))
            else $error("overflow without infinity");
        // R10: underflow always comes with a zero magnitude
        a_r10_underflow_is_zero: assert (!underflow || (result[WORD_W-2:0] == '0))
            else $error("underflow without zero");
        // R1: the canonical NaN never carries a flag
        a_r1_nan_no_flags: assert ((result != WORD_W'(quiet_nan())) || (!overflow && !underflow))
            else $error("flag raised with NaN result");
        // R5: every non-NaN result carries the XOR of the operand signs
        a_r5_sign_xor: assert ((result == WORD_W'(quiet_nan())) || (result[WORD_W-1] == (a[WORD_W-1] ^ b[WORD_W-1])))
            else $error("result sign mismatch");
    end

endmodule

// File: tb/fpmul_sp_tb_top.sv
module fpmul_sp_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        overflow;
    logic        underflow;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fpmul_sp dut_i (
        .a         (a),
        .b         (b),
        .result    (result),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // returns {overflow, underflow, result}
    function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y);
        logic [7:0]  ex, ey;
        logic [22:0] fx, fy, m;
        logic        s, g, st;
        logic [47:0] p;
        int          e;
        ex = x[30:23]; ey = y[30:23];
        fx = x[22:0];  fy = y[22:0];
        s  = x[31] ^ y[31];
        if ((ex == 8'hFF && fx != 0) || (ey == 8'hFF && fy != 0))
            return {2'b00, 32'h7FC00000};
        if ((ex == 8'hFF && ey == 8'h00) || (ey == 8'hFF && ex == 8'h00))
            return {2'b00, 32'h7FC00000};
        if (ex == 8'hFF || ey == 8'hFF)
            return {2'b10, s, 8'hFF, 23'd0};
        if (ex == 8'h00 || ey == 8'h00)
            return {2'b00, s, 31'd0};
        p = {24'd0, 1'b1, fx} * {24'd0, 1'b1, fy};
        e = int'(ex) + int'(ey) - 127;
        if (p[47]) begin
            m = p[46:24]; g = p[23]; st = |p[22:0]; e = e + 1;
        end else begin
            m = p[45:23]; g = p[22]; st = |p[21:0];
        end
        if (g && (st || m[0])) begin
            if (m == 23'h7FFFFF) begin
                m = 23'd0; e = e + 1;
            end else begin
                m = m + 23'd1;
            end
        end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
        if (e <= 0)   return {2'b01, s, 31'd0};
        return {2'b00, s, e[7:0], m};
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        a <= x;
        b <= y;
        @(negedge clk);
    endtask

    task automatic check_known(input string tag, input logic [31:0] x, input logic [31:0] y,
                               input logic [31:0] er, input logic eo, input logic eu);
        apply(x, y);
        checks++;
        if (result !== er || overflow !== eo || underflow !== eu) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual=%h/%b/%b expected=%h/%b/%b",
                     tag, x, y, result, overflow, underflow, er, eo, eu);
        end
    endtask

    task automatic check_model(input string tag, input logic [31:0] x, input logic [31:0] y);
        logic [33:0] exp_v;
        exp_v = model(x, y);
        apply(x, y);
        checks++;
        if ({overflow, underflow, result} !== exp_v) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual=%h/%b/%b expected=%h/%b/%b",
                     tag, x, y, result, overflow, underflow, exp_v[31:0], exp_v[33], exp_v[32]);
        end
    endtask

    function automatic logic [31:0] rand_op();
        logic [31:0] r;
        logic [7:0]  e;
        logic [22:0] f;
        r = $urandom;
        f = 23'($urandom);
        case (r[2:0])
            3'd0:    e = 8'd1 + 8'(r[7:4]);
            3'd1:    e = 8'd254 - 8'(r[7:4]);
            3'd2:    e = (r[8]) ? 8'hFF : 8'h00;
            3'd3:    e = 8'($urandom);
            default: e = 8'd100 + 8'(r[13:8] % 6'd55);
        endcase
        if (r[2:0] == 3'd2 && r[9]) f = 23'd0;
        return {r[31], e, f};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst <= 1'b0;

        // reset state: zero operands give +0 with no flags (R4)
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || overflow !== 1'b0 || underflow !== 1'b0) begin
            failures++;
            $display("FAIL R4 reset actual=%h/%b/%b expected=00000000/0/0", result, overflow, underflow);
        end

        check_known("R1 nan*one",     32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R1 nan*inf",     32'hFF800001, 32'h7F800000, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R1 zero*nan",    32'h00000000, 32'h7FFFFFFF, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R2 inf*zero",    32'h7F800000, 32'h80000000, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R2 zero*-inf",   32'h00000000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R2 denorm*inf",  32'h00000005, 32'h7F800000, 32'h7FC00000, 1'b0, 1'b0);
        check_known("R3 inf*-two",    32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b1, 1'b0);
        check_known("R3 -inf*-inf",   32'hFF800000, 32'hFF800000, 32'h7F800000, 1'b1, 1'b0);
        check_known("R4 zero*-three", 32'h00000000, 32'hC0400000, 32'h80000000, 1'b0, 1'b0);
        check_known("R4 -denorm*one", 32'h80000001, 32'h3F800000, 32'h80000000, 1'b0, 1'b0);
        check_known("R5 -two*three",  32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0, 1'b0);
        check_known("R5 -1.5*-1.5",   32'hBFC00000, 32'hBFC00000, 32'h40100000, 1'b0, 1'b0);
        check_known("R6 1.5*1.5",     32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0);
        check_known("R6 one*x",       32'h3F800000, 32'h4049ABCD, 32'h4049ABCD, 1'b0, 1'b0);
        check_known("R7 tie odd up",  32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0);
        check_known("R7 tie even",    32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0, 1'b0);
        check_known("R8 carry",       32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 1'b0, 1'b0);
        check_known("R9 overflow",    32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0);
        check_known("R9 -overflow",   32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, 1'b1, 1'b0);
        check_known("R9 max normal",  32'h7F000000, 32'h3FFFFFFF, 32'h7F7FFFFF, 1'b0, 1'b0);
        check_known("R10 underflow",  32'h00800000, 32'h00800000, 32'h00000000, 1'b0, 1'b1);
        check_known("R10 -underflow", 32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1);
        check_known("R10 min normal", 32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0);

        // R6 R7 R11 random mix
        for (int i = 0; i < 4000; i++) begin
            check_model("R6 R7 R11 random", rand_op(), rand_op());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("TIMEOUT watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule